// File: doc/BRIEF.md
# Flagged Arithmetic-Logic Unit

A purely combinational arithmetic-logic unit for the execute stage of a small load/store processor. Two operands of `WIDTH` bits (32 by default) and a 3-bit operation code go in; a result of the same width, a zero flag and a signed overflow flag come out in the same cycle. The unit performs bitwise AND, bitwise OR, addition, subtraction and a signed set-on-less-than.

The operation code is fixed. Its top bit selects subtraction by inverting the second operand and injecting a carry, so subtraction and set-on-less-than share the same adder path. The zero flag is meant for branch-on-equal decisions made by subtracting two registers, and the overflow flag lets the surrounding control raise an arithmetic exception.

Top module: `flagged_alu`

## Requirements
- R1: Code 3'b000 drives the result with the bitwise AND of A and B.
- R2: Code 3'b001 drives the result with the bitwise OR of A and B.
- R3: Code 3'b010 drives the result with A + B modulo 2^WIDTH.
- R4: Code 3'b110 drives the result with A - B modulo 2^WIDTH.
- R5: Code 3'b111 drives bit 0 of the result with 1 when A is less than B as two's-complement numbers and 0 otherwise, with all other bits 0; the comparison is correct even when A - B overflows.
- R6: The zero flag is 1 exactly when every bit of the result is 0, for every code.
- R7: For code 3'b010 the overflow flag is 1 exactly when A and B have the same sign and the sum's sign differs from it.
- R8: For code 3'b110 the overflow flag is 1 exactly when A and B have different signs and the difference's sign differs from the sign of A.
- R9: For codes 3'b000, 3'b001 and 3'b111 the overflow flag is 0.
- R10: The unused codes 3'b011, 3'b100 and 3'b101 drive a result of 0, a zero flag of 1 and an overflow flag of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 3 | Operation code |
| result_o | output | WIDTH | Result of the selected operation |
| zero_o | output | 1 | Result is all zeros |
| overflow_o | output | 1 | Signed overflow of add or subtract |

## Verification
The bench aims at the signed boundaries: adding one to the largest positive value and subtracting one from the most negative value, where a unit that took overflow from the carry-out instead of the sign bits would miss the flag or raise it on harmless unsigned wrap such as 1 + all-ones. It compares the most negative value against small positives and the largest positive against the most negative, where a set-on-less-than that used only the sign of the difference would give the inverted answer. Equal operands under subtraction check that the zero flag sees a full-width result, and the three unused codes check that stray adder or logic values never leak out and that the overflow flag stays low outside add and subtract.

// File: rtl/flagged_alu_pkg.sv
package flagged_alu_pkg;

  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADD  = 3'b010,
    OP_NU3  = 3'b011,
    OP_NU4  = 3'b100,
    OP_NU5  = 3'b101,
    OP_SUB  = 3'b110,
    OP_SLT  = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    K_AND   = 2'b00,
    K_OR    = 2'b01,
    K_SUM   = 2'b10,
    K_LESS  = 2'b11
  } alu_kind_e;

  typedef struct packed {
    logic      legal;
    logic      negate_b;
    alu_kind_e kind;
  } alu_ctrl_t;

  function automatic alu_ctrl_t decode_op(input logic [OP_W-1:0] op);
    alu_ctrl_t c;
    c.negate_b = op[2];
    c.kind     = alu_kind_e'(op[1:0]);
    unique case (op)
      OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT: c.legal = 1'b1;
      default:                               c.legal = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_o[i] = a_i[i] & b_i[i];
    assign or_o[i]  = a_i[i] | b_i[i];
  end

endmodule

// File: rtl/alu_addsub_unit.sv
module alu_addsub_unit #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             negate_b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o,
  output logic             less_o
);

  localparam int unsigned MSB = WIDTH - 1;

  function automatic logic [WIDTH:0] add_with_cin(
    input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y, input logic cin);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  endfunction

  function automatic logic sign_overflow(
    input logic xs, input logic ys, input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   sum_ext;

  assign b_eff   = b_i ^ {WIDTH{negate_b_i}};
  assign sum_ext = add_with_cin(a_i, b_eff, negate_b_i);
  assign sum_o   = sum_ext[MSB:0];
  assign ovf_o   = sign_overflow(a_i[MSB], b_eff[MSB], sum_ext[MSB]);
  assign less_o  = sum_ext[MSB] ^ ovf_o;

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CHUNK = 8
) (
  input  logic [WIDTH-1:0] value_i,
  output logic             zero_o
);

  localparam int unsigned NCHUNK = (WIDTH + CHUNK - 1) / CHUNK;
  localparam int unsigned PADW   = NCHUNK * CHUNK;

  logic [PADW-1:0]   padded;
  logic [NCHUNK-1:0] chunk_any;

  assign padded = {{(PADW-WIDTH){1'b0}}, value_i};

  for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
    assign chunk_any[c] = |padded[c*CHUNK +: CHUNK];
  end

  assign zero_o = ~|chunk_any;

endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
  import flagged_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             zero_o,
  output logic             overflow_o
);

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] and_w;
  logic [WIDTH-1:0] or_w;
  logic [WIDTH-1:0] sum_w;
  logic             ovf_raw;
  logic             less_w;
  logic             is_arith;
  logic [WIDTH-1:0] res_w;

  assign ctrl = decode_op(op_i);

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .and_o (and_w),
    .or_o  (or_w)
  );

  alu_addsub_unit #(.WIDTH(WIDTH)) u_addsub (
    .a_i        (a_i),
    .b_i        (b_i),
    .negate_b_i (ctrl.negate_b),
    .sum_o      (sum_w),
    .ovf_o      (ovf_raw),
    .less_o     (less_w)
  );

  always_comb begin
    res_w = '0;
    if (ctrl.legal) begin
      unique case (ctrl.kind)
        K_AND:  res_w = and_w;
        K_OR:   res_w = or_w;
        K_SUM:  res_w = sum_w;
        K_LESS: res_w = {{(WIDTH-1){1'b0}}, less_w};
      endcase
    end
  end

  assign is_arith = ctrl.legal && (ctrl.kind == K_SUM);

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .value_i (res_w),
    .zero_o  (zero_o)
  );

  assign result_o   = res_w;
  assign overflow_o = is_arith & ovf_raw;

endmodule

// File: rtl/flagged_alu_checker.sv
module flagged_alu_checker #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             overflow_o,
  input logic [WIDTH-1:0] sum_w,
  input logic             less_w,
  input logic             is_arith
);

  localparam int unsigned MSB = WIDTH - 1;

  always_comb begin
    if (op_i == 3'b000) a_r1_and: assert (result_o == (a_i & b_i));
    if (op_i == 3'b001) a_r2_or: assert (result_o == (a_i | b_i));
    if (op_i == 3'b010) a_r3_add: assert (result_o - b_i == a_i);
    if (op_i == 3'b110) a_r4_sub: assert (result_o + b_i == a_i);
    if (op_i == 3'b111) a_r5_slt: assert (result_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))});
    a_r6_zero: assert (zero_o == (result_o == '0));
    if (op_i == 3'b010) a_r7_add_ovf: assert (overflow_o ==
      ((a_i[MSB] == b_i[MSB]) && (sum_w[MSB] != a_i[MSB])));
    if (op_i == 3'b110) a_r8_sub_ovf: assert (overflow_o ==
      ((a_i[MSB] != b_i[MSB]) && (sum_w[MSB] != a_i[MSB])));
    if (!is_arith) a_r9_no_overflow: assert (!overflow_o);
    if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)
      a_r10_unused: assert (result_o == '0 && zero_o && !overflow_o);
    if (op_i == 3'b111) a_r5_less_lane: assert (result_o[0] == less_w);
  end

endmodule

bind flagged_alu flagged_alu_checker #(.WIDTH(WIDTH)) u_checker (
  .a_i        (a_i),
  .b_i        (b_i),
  .op_i       (op_i),
  .result_o   (result_o),
  .zero_o     (zero_o),
  .overflow_o (overflow_o),
  .sum_w      (sum_w),
  .less_w     (less_w),
  .is_arith   (is_arith)
);

// File: tb/flagged_alu_tb.sv
`timescale 1ns/1ps
module flagged_alu_tb;

  localparam int unsigned W = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [2:0]   op;
  logic         zf, of;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  flagged_alu #(.WIDTH(W)) u_dut (
    .a_i(a), .b_i(b), .op_i(op),
    .result_o(res), .zero_o(zf), .overflow_o(of)
  );

  function automatic logic [W-1:0] exp_res(input logic [W-1:0] x, input logic [W-1:0] y,
                                            input logic [2:0] c);
    logic signed [W:0] sx, sy;
    sx = {x[W-1], x};
    sy = {y[W-1], y};
    case (c)
      3'b000: return x & y;
      3'b001: return x | y;
      3'b010: return x + y;
      3'b110: return x + (~y) + 1;
      3'b111: return (sx < sy) ? 1 : 0;
      default: return '0;
    endcase
  endfunction

  function automatic logic exp_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [2:0] c);
    logic signed [W+1:0] wide;
    logic signed [W+1:0] lo, hi;
    lo = -(2**(W-1));
    hi = (2**(W-1)) - 1;
    if (c == 3'b010) wide = $signed({{2{x[W-1]}}, x}) + $signed({{2{y[W-1]}}, y});
    else if (c == 3'b110) wide = $signed({{2{x[W-1]}}, x}) - $signed({{2{y[W-1]}}, y});
    else return 1'b0;
    return (wide < lo) || (wide > hi);
  endfunction

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic apply_check(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] c);
    logic [W-1:0] er;
    logic eo;
    @(posedge clk);
    a = x; b = y; op = c;
    @(negedge clk);
    er = exp_res(x, y, c);
    eo = exp_ovf(x, y, c);
    compared++;
    if (res !== er) begin
      mismatched++;
      $display("FAIL %s result op=%b a=%h b=%h actual=%h expected=%h", req_of(c), c, x, y, res, er);
    end
    compared++;
    if (zf !== (er == '0)) begin
      mismatched++;
      $display("FAIL R6 zero op=%b a=%h b=%h actual=%b expected=%b", c, x, y, zf, (er == '0));
    end
    compared++;
    if (of !== eo) begin
      mismatched++;
      $display("FAIL %s overflow op=%b a=%h b=%h actual=%b expected=%b",
               (c == 3'b010) ? "R7" : (c == 3'b110) ? "R8" : "R9", c, x, y, of, eo);
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] maxp, minn;
    void'($urandom(32'h5EED_0A1C));
    maxp = {1'b0, {(W-1){1'b1}}};
    minn = {1'b1, {(W-1){1'b0}}};
    a = '0; b = '0; op = 3'b000;
    // initial state: zero inputs, AND gives zero with zero flag (R1, R6)
    apply_check('0, '0, 3'b000);
    // R1 / R2 patterns
    apply_check(32'hF0F0_A5A5, 32'h0FF0_FFFF, 3'b000);
    apply_check(32'hF0F0_A5A5, 32'h0FF0_0000, 3'b001);
    // R3 / R7 boundaries
    apply_check(maxp, 1, 3'b010);
    apply_check(minn, minn, 3'b010);
    apply_check(1, '1, 3'b010);
    apply_check(minn, maxp, 3'b010);
    // R4 / R8 boundaries
    apply_check(minn, 1, 3'b110);
    apply_check(maxp, '1, 3'b110);
    apply_check(32'h1234_5678, 32'h1234_5678, 3'b110);
    apply_check('0, minn, 3'b110);
    // R5 signed compare, including overflowing difference
    apply_check(minn, 1, 3'b111);
    apply_check(maxp, minn, 3'b111);
    apply_check('1, '0, 3'b111);
    apply_check(5, 5, 3'b111);
    // R10 unused codes with operands that would produce nonzero values
    apply_check('1, '1, 3'b011);
    apply_check(maxp, 1, 3'b100);
    apply_check(minn, 1, 3'b101);
    // random mix over all codes (R1-style coverage of every requirement)
    for (int i = 0; i < 2400; i++) begin
      logic [W-1:0] x, y;
      logic [2:0] c;
      x = $urandom;
      y = $urandom;
      c = 3'($urandom_range(0, 7));
      if (i % 16 == 0) y = x;
      if (i % 16 == 1) x = maxp ^ {{(W-4){1'b0}}, 4'($urandom)};
      if (i % 16 == 2) y = minn | {{(W-4){1'b0}}, 4'($urandom)};
      apply_check(x, y, c);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule